// File: doc/BRIEF.md
# Synchronized Multi-Channel Timer Group

The block holds six 16-bit up-counters. Each counter has its own run bit, compare register, control register and one output pin. All of them are reached through a single-cycle register write port and a combinational read port. On a compare match, a channel can return its counter to zero. The same match also drives, sets low, sets high or toggles the channel's pin.

Channels can be joined into a coupled set through a per-channel coupling mask. The coupling takes effect only when two or more mask bits are set. While it is in effect, writing the counter of any coupled channel loads that value into every coupled counter in the same cycle. In addition, a coupled channel whose clear-source field selects the coupled-clear code returns to zero in the cycle in which any coupled channel clears on its own match. This happens even if that channel is stopped.

Stopping a channel freezes both its count and its pin. A control-register write made while the channel is stopped moves the pin at once to the programmed initial level.

Top module: `sync_timer_group`

## Requirements
- R1: After reset, the run register and the coupling register read 0, every counter reads 0, every compare register reads 0xFFFF, and every pin is low.
- R2: Run and coupling registers:
  - The run register is at address 0x00 and the coupling register is at address 0x01.
  - Bit n of each register belongs to channel n. Bits 7:6 are ignored on write and read as 0.
  - A running channel's counter advances by one on every clock.
- R3: A running channel whose clear-source field is 001 reads its compare value for one cycle and then reads 0, so its period is compare+1 clocks.
- R4: On a compare match of a running channel, the action field changes the pin: 00 leaves it unchanged, 01 drives it low, 10 drives it high and 11 toggles it.
- R5: A stopped channel keeps its counter value and its pin level.
- R6: Writing a channel's control register sets the pin to the init-level bit, but only if the channel is stopped. A write made while the channel runs leaves the pin unchanged.
- R7: With two or more coupling bits set, a write to any coupled channel's counter loads the same value into every coupled counter, running or stopped. Uncoupled counters keep counting undisturbed.
- R8: A single set coupling bit gives independent operation. A write to that channel's counter loads only that counter.
- R9: A coupled channel with clear-source 011 reads 0 in the same cycle as a coupled channel with clear-source 001 that has cleared on its own match. This holds even when the 011 channel is stopped.
- R10: Clear-source 011 on a channel that is not coupled never clears the counter. Codes other than 001 and 011 (for example 010) never clear it either.

Register map:
- Channel n registers sit at 0x20 + 4n:
  - +0 is the counter.
  - +1 is the compare register.
  - +2 is the control register.
- Control register fields:
  - Bit 5 is the init level.
  - Bits 4:3 are the action.
  - Bits 2:0 are the clear source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Combinational read data |
| pin_out | output | 6 | Per-channel compare output pins |

## Verification
The bench targets the following cases, each of which catches a specific fault:
- **Single coupling bit.** A design that counts mask bits wrongly would copy a counter write into a channel that should stay independent.
- **Stopped clear-on-coupled channel.** This channel must still reach zero in the exact cycle its partner wraps. Gating the clear with the run bit would leave it at its old value, and registering the clear pulse would zero it one cycle late.
- **Control writes.** These are made both to stopped channels and to running ones. Drive the pin while running and it jumps early; skip the drive when stopped and it keeps a stale level.
- **Clear-source 011 on an uncoupled channel and code 010.** Both are checked to confirm that neither clears.
- **All four pin actions.** Each is exercised, which exposes an action decoder with swapped codes.

// File: rtl/stg_pkg.sv
package stg_pkg;

    localparam logic [2:0] CLR_NEVER  = 3'b000;
    localparam logic [2:0] CLR_OWN    = 3'b001;
    localparam logic [2:0] CLR_COUPLE = 3'b011;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        SEL_CNT = 2'b00,
        SEL_CMP = 2'b01,
        SEL_CTL = 2'b10,
        SEL_RSV = 2'b11
    } sel_e;

    typedef struct packed {
        logic       init_lvl;
        act_e       act;
        logic [2:0] clr_src;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic pin_after_match(act_e a, logic cur);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/stg_group_regs.sv
module stg_group_regs #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_run,
    input  logic           wr_couple,
    input  logic [NCH-1:0] wr_bits,
    output logic [NCH-1:0] run_q,
    output logic [NCH-1:0] couple_q,
    output logic [NCH-1:0] eff_couple
);
    localparam int CNTW = $clog2(NCH + 1);

    logic [CNTW-1:0] ones;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            couple_q <= '0;
        end else begin
            if (wr_run)    run_q    <= wr_bits;
            if (wr_couple) couple_q <= wr_bits;
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < NCH; i++) ones = ones + CNTW'(couple_q[i]);
    end

    assign eff_couple = (ones >= CNTW'(2)) ? couple_q : '0;

endmodule

// File: rtl/stg_channel.sv
module stg_channel
    import stg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          coupled,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          cmp_wr,
    input  logic          ctl_wr,
    input  ctl_t          ctl_val,
    input  logic          couple_clr,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cmp,
    output ctl_t          ctl,
    output logic          pin,
    output logic          own_clr
);
    logic match;

    assign match   = run && (cnt == cmp);
    assign own_clr = match && (ctl.clr_src == CLR_OWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (own_clr) begin
            cnt <= '0;
        end else if (couple_clr && coupled && ctl.clr_src == CLR_COUPLE) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= '1;
            ctl <= '0;
        end else begin
            if (cmp_wr) cmp <= load_val;
            if (ctl_wr) ctl <= ctl_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else if (ctl_wr && !run) begin
            pin <= ctl_val.init_lvl;
        end else if (match) begin
            pin <= pin_after_match(ctl.act, pin);
        end
    end

endmodule

// File: rtl/sync_timer_group.sv
module sync_timer_group
    import stg_pkg::*;
#(
    parameter int NCH = 6,
    parameter int CW  = 16,
    parameter int AW  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    output logic [NCH-1:0] pin_out
);
    localparam int SB  = 2;
    localparam int CHB = $clog2(NCH);
    localparam logic [AW-1:0] A_RUN    = AW'(0);
    localparam logic [AW-1:0] A_COUPLE = AW'(1);

    logic [NCH-1:0]         run_q, couple_q, eff_sync, start_q;
    logic [NCH-1:0]         cnt_req, cmp_req, ctl_wr, cnt_ld, own_clr;
    logic [NCH-1:0][CW-1:0] cnt_all, cmp_all;
    logic [NCH-1:0][2:0]    src_all;
    ctl_t [NCH-1:0]         ctl_all;
    logic                   sclr, sync_load;
    logic                   wr_chan;
    logic [CHB-1:0]         wr_ch, rd_ch;
    sel_e                   wr_sel, rd_sel;

    assign wr_chan = wr_addr[AW-1];
    assign wr_ch   = wr_addr[SB+CHB-1:SB];
    assign wr_sel  = sel_e'(wr_addr[SB-1:0]);
    assign rd_ch   = rd_addr[SB+CHB-1:SB];
    assign rd_sel  = sel_e'(rd_addr[SB-1:0]);

    stg_group_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_run    (wr_en && wr_addr == A_RUN),
        .wr_couple (wr_en && wr_addr == A_COUPLE),
        .wr_bits   (wr_data[NCH-1:0]),
        .run_q     (run_q),
        .couple_q  (couple_q),
        .eff_couple(eff_sync)
    );

    assign start_q   = run_q;
    assign sync_load = |(cnt_req & eff_sync);
    assign sclr      = |(own_clr & eff_sync);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic hit;
        assign hit        = wr_en && wr_chan && wr_ch == CHB'(n);
        assign cnt_req[n] = hit && wr_sel == SEL_CNT;
        assign cmp_req[n] = hit && wr_sel == SEL_CMP;
        assign ctl_wr[n]  = hit && wr_sel == SEL_CTL;
        assign cnt_ld[n]  = cnt_req[n] || (sync_load && eff_sync[n]);
        assign src_all[n] = ctl_all[n].clr_src;

        stg_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (run_q[n]),
            .coupled   (eff_sync[n]),
            .load      (cnt_ld[n]),
            .load_val  (wr_data),
            .cmp_wr    (cmp_req[n]),
            .ctl_wr    (ctl_wr[n]),
            .ctl_val   (ctl_t'(wr_data[CTL_W-1:0])),
            .couple_clr(sclr),
            .cnt       (cnt_all[n]),
            .cmp       (cmp_all[n]),
            .ctl       (ctl_all[n]),
            .pin       (pin_out[n]),
            .own_clr   (own_clr[n])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_RUN) begin
            rd_data = CW'(run_q);
        end else if (rd_addr == A_COUPLE) begin
            rd_data = CW'(couple_q);
        end else if (rd_addr[AW-1] && int'(rd_ch) < NCH) begin
            case (rd_sel)
                SEL_CNT: rd_data = cnt_all[rd_ch];
                SEL_CMP: rd_data = cmp_all[rd_ch];
                SEL_CTL: rd_data = CW'(ctl_all[rd_ch]);
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
    parameter int NCH = 6,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCH-1:0]         start_q,
    input logic [NCH-1:0]         eff_sync,
    input logic [NCH-1:0][CW-1:0] cnt_all,
    input logic [NCH-1:0][CW-1:0] cmp_all,
    input logic [NCH-1:0][2:0]    src_all,
    input logic [NCH-1:0]         pin_out,
    input logic [NCH-1:0]         cnt_ld,
    input logic [NCH-1:0]         cnt_req,
    input logic [NCH-1:0]         ctl_wr,
    input logic                   sclr,
    input logic [CW-1:0]          wr_data
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (start_q == '0 && cnt_all == '0 && pin_out == '0));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        logic own_wrap, cpl_clr;
        assign own_wrap = start_q[n] && src_all[n] == 3'b001 && cnt_all[n] == cmp_all[n];
        assign cpl_clr  = sclr && eff_sync[n] && src_all[n] == 3'b011;

        assert_run_count_R2: assert property (@(posedge clk) disable iff (rst)
            (start_q[n] && !cnt_ld[n] && !own_wrap && !cpl_clr)
            |=> cnt_all[n] == $past(cnt_all[n]) + CW'(1));

        assert_own_clear_R3: assert property (@(posedge clk) disable iff (rst)
            (own_wrap && !cnt_ld[n]) |=> cnt_all[n] == '0);

        assert_stop_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (!start_q[n] && !cnt_ld[n] && !cpl_clr) |=> $stable(cnt_all[n]));

        assert_pin_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (!start_q[n] && !ctl_wr[n]) |=> $stable(pin_out[n]));

        assert_sync_preset_R7: assert property (@(posedge clk) disable iff (rst)
            ((|(cnt_req & eff_sync)) && eff_sync[n]) |=> cnt_all[n] == $past(wr_data));

        assert_sync_clear_R9: assert property (@(posedge clk) disable iff (rst)
            (cpl_clr && !cnt_ld[n]) |=> cnt_all[n] == '0);
    end

endmodule

bind sync_timer_group stg_checker #(.NCH(NCH), .CW(CW)) chk (
    .clk     (clk),
    .rst     (rst),
    .start_q (start_q),
    .eff_sync(eff_sync),
    .cnt_all (cnt_all),
    .cmp_all (cmp_all),
    .src_all (src_all),
    .pin_out (pin_out),
    .cnt_ld  (cnt_ld),
    .cnt_req (cnt_req),
    .ctl_wr  (ctl_wr),
    .sclr    (sclr),
    .wr_data (wr_data)
);

// File: tb/sync_timer_group_test.sv
module sync_timer_group_test;
    localparam int NCH = 6;
    localparam int CW  = 16;
    localparam int AW  = 6;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_C = 2'd1;
    localparam logic [1:0] OP_P = 2'd2;
    localparam logic [1:0] OP_I = 2'd3;

    localparam int NV = 29;
    // {op, addr, data, requirement}
    localparam logic [31:0] VEC [NV] = '{
        {OP_C, 6'h00, 16'h0000, 8'd1},  // R1 run reg
        {OP_C, 6'h01, 16'h0000, 8'd1},  // R1 coupling reg
        {OP_C, 6'h20, 16'h0000, 8'd1},  // R1 counter
        {OP_C, 6'h21, 16'hFFFF, 8'd1},  // R1 compare
        {OP_P, 6'h00, 16'h0000, 8'd1},  // R1 pins
        {OP_W, 6'h21, 16'h0005, 8'd3},
        {OP_W, 6'h22, 16'h0039, 8'd6},  // init 1, toggle, own clear
        {OP_P, 6'h00, 16'h0001, 8'd6},  // R6 stopped write drives pin
        {OP_W, 6'h20, 16'h0002, 8'd2},
        {OP_W, 6'h00, 16'h0001, 8'd2},
        {OP_C, 6'h20, 16'h0002, 8'd2},  // R2
        {OP_I, 6'h00, 16'h0003, 8'd2},
        {OP_C, 6'h20, 16'h0005, 8'd2},  // R2 counts
        {OP_P, 6'h00, 16'h0001, 8'd4},
        {OP_I, 6'h00, 16'h0001, 8'd3},
        {OP_C, 6'h20, 16'h0000, 8'd3},  // R3 wrap
        {OP_P, 6'h00, 16'h0000, 8'd4},  // R4 toggle
        {OP_I, 6'h00, 16'h0006, 8'd3},
        {OP_C, 6'h20, 16'h0000, 8'd3},  // R3 period 6
        {OP_P, 6'h00, 16'h0001, 8'd4},  // R4 toggle back
        {OP_W, 6'h00, 16'h0000, 8'd5},
        {OP_I, 6'h00, 16'h0004, 8'd5},
        {OP_C, 6'h20, 16'h0001, 8'd5},  // R5 count frozen
        {OP_P, 6'h00, 16'h0001, 8'd5},  // R5 pin frozen
        {OP_W, 6'h00, 16'h00C0, 8'd2},
        {OP_C, 6'h00, 16'h0000, 8'd2},  // R2 bits 7:6 ignored
        {OP_W, 6'h22, 16'h0019, 8'd6},
        {OP_P, 6'h00, 16'h0000, 8'd6},  // R6 init 0
        {OP_C, 6'h22, 16'h0019, 8'd6}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic [NCH-1:0] pin_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    logic [CW-1:0] v4;

    always #10 clk = ~clk;

    sync_timer_group #(.NCH(NCH), .CW(CW), .AW(AW)) uut (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .pin_out(pin_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL R1 watchdog: actual %0d cycles expected below 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk_rd(input logic [AW-1:0] a, input logic [CW-1:0] e, input string tag);
        rd_addr = a;
        #1;
        n_chk++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s addr %h: actual %h expected %h", tag, a, rd_data, e);
        end
    endtask

    task automatic chk_pin(input logic [NCH-1:0] e, input string tag);
        #1;
        n_chk++;
        if (pin_out !== e) begin
            n_bad++;
            $display("FAIL %s pins: actual %b expected %b", tag, pin_out, e);
        end
    endtask

    initial begin
        idle(3);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]    op;
            logic [AW-1:0] a;
            logic [CW-1:0] d;
            int            r;
            op = VEC[i][31:30];
            a  = VEC[i][29:24];
            d  = VEC[i][23:8];
            r  = int'(VEC[i][7:0]);
            case (op)
                OP_W: wr(a, d);
                OP_C: chk_rd(a, d, $sformatf("R%0d vec %0d", r, i));
                OP_P: chk_pin(d[NCH-1:0], $sformatf("R%0d vec %0d", r, i));
                default: idle(int'(d));
            endcase
        end

        // R6: control write while running leaves pin alone
        wr(6'h00, 16'h0002);
        wr(6'h26, 16'h0020);
        chk_pin(6'b000000, "R6 running");
        wr(6'h00, 16'h0000);

        // R8: single coupling bit is independent
        wr(6'h01, 16'h0004);
        wr(6'h28, 16'h1234);
        chk_rd(6'h28, 16'h1234, "R8 own load");
        chk_rd(6'h2C, 16'h0000, "R8 other untouched");

        // R7: coupled preset, uncoupled keeps counting
        wr(6'h01, 16'h000C);
        wr(6'h00, 16'h0014);
        rd_addr = 6'h30; #1; v4 = rd_data;
        wr(6'h2C, 16'h0100);
        chk_rd(6'h28, 16'h0100, "R7 running coupled");
        chk_rd(6'h2C, 16'h0100, "R7 stopped coupled");
        chk_rd(6'h30, v4 + 16'd1, "R7 uncoupled");

        // R9: stopped coupled channel cleared with partner
        wr(6'h00, 16'h0000);
        wr(6'h2A, 16'h0001);
        wr(6'h29, 16'h000A);
        wr(6'h2E, 16'h0003);
        wr(6'h28, 16'h0007);
        chk_rd(6'h2C, 16'h0007, "R7 preset stopped");
        wr(6'h00, 16'h0004);
        idle(3);
        chk_rd(6'h28, 16'h000A, "R3 at compare");
        chk_rd(6'h2C, 16'h0007, "R9 before clear");
        idle(1);
        chk_rd(6'h28, 16'h0000, "R3 wrap");
        chk_rd(6'h2C, 16'h0000, "R9 same cycle clear");

        // R10: code 010 never clears
        wr(6'h00, 16'h0000);
        wr(6'h32, 16'h0002);
        wr(6'h31, 16'h0003);
        wr(6'h30, 16'h0000);
        wr(6'h00, 16'h0010);
        idle(10);
        chk_rd(6'h30, 16'h000A, "R10 code 010");
        wr(6'h00, 16'h0000);

        // R10: code 011 on uncoupled channel never clears
        wr(6'h01, 16'h0005);
        wr(6'h2C, 16'h0004);
        wr(6'h28, 16'h0009);
        chk_rd(6'h20, 16'h0009, "R7 ch0 preset");
        wr(6'h00, 16'h0004);
        idle(2);
        chk_rd(6'h28, 16'h0000, "R3 ch2 wrap");
        chk_rd(6'h2C, 16'h0004, "R10 uncoupled 011");
        chk_rd(6'h20, 16'h0009, "R9 src 001 not cleared by partner");
        wr(6'h00, 16'h0000);
        wr(6'h01, 16'h0000);

        // R4: high, low, hold actions on channel 5
        wr(6'h36, 16'h0011);
        wr(6'h35, 16'h0002);
        wr(6'h34, 16'h0000);
        chk_pin(6'b000000, "R4 start");
        wr(6'h00, 16'h0020);
        idle(3);
        chk_pin(6'b100000, "R4 drive high");
        chk_rd(6'h34, 16'h0000, "R3 ch5 wrap");
        wr(6'h00, 16'h0000);
        wr(6'h36, 16'h0029);
        chk_pin(6'b100000, "R6 init high");
        wr(6'h00, 16'h0020);
        idle(2);
        chk_pin(6'b000000, "R4 drive low");
        wr(6'h00, 16'h0000);
        wr(6'h36, 16'h0021);
        wr(6'h00, 16'h0020);
        idle(2);
        chk_pin(6'b100000, "R4 no change");
        chk_rd(6'h34, 16'h0000, "R3 ch5 wrap hold");

        // R1: reset in the middle of operation
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        chk_rd(6'h00, 16'h0000, "R1 run after reset");
        chk_rd(6'h34, 16'h0000, "R1 counter after reset");
        chk_rd(6'h35, 16'hFFFF, "R1 compare after reset");
        chk_pin(6'b000000, "R1 pins after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule